// File: doc/BRIEF.md
# Queue Status Interrupt Generator

This block turns the status flags of sixty-four queues into two level-sensitive interrupt lines. The queues form two groups. The lower group covers queues 0 to 31 and drives `irq_lo`. The upper group covers queues 32 to 63 and drives `irq_hi`.

Each lower queue has a 3-bit trigger code. The code picks one of four flags (empty, nearly empty, nearly full, full) and says whether the rising or the falling transition of that flag is the event. An upper queue has no choice: its event is always the rising transition of its nearly-empty flag.

Every event sets a sticky pending bit. Software clears a pending bit by writing a one to it. A pending bit drives its group's interrupt line only while the queue's enable bit is set.

Top module: `qstat_irq_gen`

## Requirements
- R1: After reset, all pending bits, enable bits and trigger codes read as zero, and both `irq_lo` and `irq_hi` are low.
- R2: The trigger code of a lower queue is `{falling, sel[1:0]}`, with sel 00 = empty, 01 = nearly empty, 10 = nearly full and 11 = full. Only transitions of the selected flag can set that queue's pending bit.
- R3: A lower queue with falling = 0 records a 0-to-1 transition of its selected flag. With falling = 1 it records a 1-to-0 transition. The opposite transition is ignored.
- R4: An upper queue records only a 0-to-1 transition of its nearly-empty flag. A 1-to-0 transition is ignored.
- R5: A pending bit is set on the clock edge that samples the flag transition. It stays set after the flag returns to its previous level.
- R6: Writing the pending-status word clears each pending bit written with one. Bits written with zero are unchanged.
- R7: If an event and a clearing write hit the same pending bit on the same clock edge, the bit stays set.
- R8: `irq_lo` is high exactly when some lower queue is both pending and enabled. `irq_hi` follows the same rule for the upper group. The two lines are independent of each other.
- R9: The enable bits do not gate event capture. A disabled queue still records events, and it raises its interrupt line as soon as it is enabled.
- R10: Word addresses are: 0 = lower pending, 1 = upper pending, 2 = lower enable, 3 = upper enable, 4 to 7 = lower trigger codes. Queue q's code sits in word 4 + q/8 at bits [4*(q%8)+2 : 4*(q%8)], and bit 4*(q%8)+3 reads zero. Bit n of words 0 to 3 belongs to queue n of that group. Reads of other addresses return zero, and writes to them change nothing.
- R11: Flag levels held across reset release do not create events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_empty | input | 32 | Empty flag of each lower queue |
| lo_nempty | input | 32 | Nearly-empty flag of each lower queue |
| lo_nfull | input | 32 | Nearly-full flag of each lower queue |
| lo_full | input | 32 | Full flag of each lower queue |
| hi_nempty | input | 32 | Nearly-empty flag of each upper queue |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_lo | output | 1 | Interrupt line of queues 0 to 31 |
| irq_hi | output | 1 | Interrupt line of queues 32 to 63 |

## Verification
Event capture and the write-one-to-clear path can hit the same pending bit on one clock edge. The bench provokes this on purpose: it raises an upper queue's nearly-empty flag in the same cycle that it writes a one to that queue's pending bit, and it expects the bit to read back as one (set wins). A long random phase then toggles flags and issues writes together. A cycle-level model of the bench computes the next pending word as the old word with the written ones removed, plus the events. Every cycle, the bench compares the interrupt lines and one register readback against that model.

// File: rtl/qirq_pkg.sv
// Package: shared types and the register word map of the queue status
// interrupt generator.
package qirq_pkg;

    // Flag chosen as the trigger of a lower queue.
    typedef enum logic [1:0] {
        FSEL_EMPTY  = 2'b00,
        FSEL_NEMPTY = 2'b01,
        FSEL_NFULL  = 2'b10,
        FSEL_FULL   = 2'b11
    } fsel_e;

    // Per-queue trigger code: bit 2 chooses the falling transition.
    typedef struct packed {
        logic  falling;
        fsel_e sel;
    } qcfg_t;

    // Word addresses of the register map.
    localparam int ADDR_PEND_LO = 0;
    localparam int ADDR_PEND_HI = 1;
    localparam int ADDR_EN_LO   = 2;
    localparam int ADDR_EN_HI   = 3;
    localparam int ADDR_CFG0    = 4;

    // Bits spent on one trigger code inside a config word.
    localparam int CFG_SLOT = 4;

endpackage

// File: rtl/qirq_lo_detect.sv
// Module: qirq_lo_detect
// Finds the configured flag transition of each lower queue. It keeps
// the previous level of all four flags. That way a change of the trigger
// code compares like with like and never creates a false event.
// Assumes: flags are synchronous to clk. During reset the history
// follows the inputs, so levels held across reset release are not
// seen as edges.
module qirq_lo_detect
    import qirq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      f_empty,
    input  logic [N-1:0]      f_nempty,
    input  logic [N-1:0]      f_nfull,
    input  logic [N-1:0]      f_full,
    input  qcfg_t [N-1:0]     cfg,
    output logic [N-1:0]      ev
);

    logic [N-1:0] p_empty, p_nempty, p_nfull, p_full;
    logic [N-1:0] cur_sel, prv_sel, fall_vec;

    // History of all four flags. It is loaded in reset as well, which
    // gives R11.
    always_ff @(posedge clk) begin
        p_empty  <= f_empty;
        p_nempty <= f_nempty;
        p_nfull  <= f_nfull;
        p_full   <= f_full;
    end

    for (genvar q = 0; q < N; q++) begin : g_q
        // Pick the current and previous level of the selected flag.
        always_comb begin
            unique case (cfg[q].sel)
                FSEL_EMPTY:  begin cur_sel[q] = f_empty[q];  prv_sel[q] = p_empty[q];  end
                FSEL_NEMPTY: begin cur_sel[q] = f_nempty[q]; prv_sel[q] = p_nempty[q]; end
                FSEL_NFULL:  begin cur_sel[q] = f_nfull[q];  prv_sel[q] = p_nfull[q];  end
                default:     begin cur_sel[q] = f_full[q];   prv_sel[q] = p_full[q];   end
            endcase
        end
        assign fall_vec[q] = cfg[q].falling;
        // Event on the chosen direction of the chosen flag.
        assign ev[q] = fall_vec[q] ? (prv_sel[q] & ~cur_sel[q])
                                   : (cur_sel[q] & ~prv_sel[q]);
    end

    // R3: a rising-edge queue reports only when its flag is now high.
    a_r3_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ~fall_vec & ~cur_sel) == '0));
    // R3: a falling-edge queue reports only when its flag is now low.
    a_r3_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & fall_vec & cur_sel) == '0));

endmodule

// File: rtl/qirq_hi_detect.sv
// Module: qirq_hi_detect
// Finds the rising transition of the nearly-empty flag of each upper
// queue.
// Assumes: flags are synchronous to clk. The history follows the
// inputs during reset.
module qirq_hi_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] f_nempty,
    output logic [N-1:0] ev
);

    logic [N-1:0] p_nempty;

    // History of the nearly-empty flags (also loaded during reset).
    always_ff @(posedge clk) begin
        p_nempty <= f_nempty;
    end

    // Rising transition only.
    assign ev = f_nempty & ~p_nempty;

    // R4: no event while the flag is low.
    a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ~f_nempty) == '0));
    // R4: an event always follows a recorded low level.
    a_r4_prev_low: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(ev) & $past(f_nempty) & ~p_nempty) == '0));

endmodule

// File: rtl/qirq_sticky.sv
// Module: qirq_sticky
// Sticky pending bits with write-one-to-clear. When an event and a clear
// hit the same bit on one edge, the event wins.
// Assumes: ev and clr are single-cycle pulses that are valid at the
// clock edge.
module qirq_sticky #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    // Clear the written ones, then add the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | ev;
    end

    // R7: every event seen on an edge is pending after it.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & $past(ev)) == $past(ev)));
    // R6: a bit falls only if a one was written to it.
    a_r6_clear_only_written: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(pend) & ~pend & ~$past(clr)) == '0));
    // R5: a bit rises only with an event.
    a_r5_set_only_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & ~$past(pend) & ~$past(ev)) == '0));

endmodule

// File: rtl/qirq_regfile.sv
// Module: qirq_regfile
// Holds the enable and trigger-code registers. It decodes the clear
// masks for the pending words and multiplexes the read data.
// Assumes: NLO and NHI are no larger than DW, and NLO is a multiple of
// the number of trigger codes per word.
module qirq_regfile
    import qirq_pkg::*;
#(
    parameter int NLO = 32,
    parameter int NHI = 32,
    parameter int DW  = 32,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NLO-1:0]    pend_lo,
    input  logic [NHI-1:0]    pend_hi,
    output logic [NLO-1:0]    en_lo,
    output logic [NHI-1:0]    en_hi,
    output qcfg_t [NLO-1:0]   cfg,
    output logic [NLO-1:0]    clr_lo,
    output logic [NHI-1:0]    clr_hi,
    output logic [DW-1:0]     rdata
);

    localparam int QPW       = DW / CFG_SLOT;
    localparam int CFG_WORDS = (NLO + QPW - 1) / QPW;
    localparam int ADDR_END  = ADDR_CFG0 + CFG_WORDS;

    logic wr_en_lo, wr_en_hi;

    assign wr_en_lo = we && (addr == AW'(ADDR_EN_LO));
    assign wr_en_hi = we && (addr == AW'(ADDR_EN_HI));

    // Write-one-to-clear masks for the pending words.
    assign clr_lo = (we && addr == AW'(ADDR_PEND_LO)) ? wdata[NLO-1:0] : '0;
    assign clr_hi = (we && addr == AW'(ADDR_PEND_HI)) ? wdata[NHI-1:0] : '0;

    // Enable registers of both groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lo <= '0;
            en_hi <= '0;
        end else begin
            if (wr_en_lo) en_lo <= wdata[NLO-1:0];
            if (wr_en_hi) en_hi <= wdata[NHI-1:0];
        end
    end

    for (genvar q = 0; q < NLO; q++) begin : g_cfg
        localparam int WORD = q / QPW;
        localparam int LSB  = (q % QPW) * CFG_SLOT;
        // Trigger code of lower queue q.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[q] <= '0;
            else if (we && addr == AW'(ADDR_CFG0 + WORD))
                cfg[q] <= qcfg_t'(wdata[LSB +: 3]);
        end
    end

    // Read multiplexer: zero for unmapped words and unused bits.
    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_PEND_LO)) rdata[NLO-1:0] = pend_lo;
        if (addr == AW'(ADDR_PEND_HI)) rdata[NHI-1:0] = pend_hi;
        if (addr == AW'(ADDR_EN_LO))   rdata[NLO-1:0] = en_lo;
        if (addr == AW'(ADDR_EN_HI))   rdata[NHI-1:0] = en_hi;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (addr == AW'(ADDR_CFG0 + w)) begin
                for (int k = 0; k < QPW; k++)
                    rdata[k*CFG_SLOT +: 3] = cfg[w*QPW + k];
            end
        end
    end

    // R10: writes outside the map leave every register unchanged.
    a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr >= AW'(ADDR_END)) |=>
            ($stable(en_lo) && $stable(en_hi) && $stable(cfg)));
    // R6: a clear mask appears only with a write strobe.
    a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |-> (clr_lo == '0 && clr_hi == '0));

endmodule

// File: rtl/qstat_irq_gen.sv
// Module: qstat_irq_gen (top)
// Queue status interrupt generator for two groups of queues. Lower
// queues use a programmable flag and transition; upper queues use the
// rise of nearly-empty. Each group drives a level interrupt made from
// its enabled pending bits.
// Assumes: flags are synchronous to clk; reset is synchronous and
// active low.
module qstat_irq_gen
    import qirq_pkg::*;
#(
    parameter int NLO = 32,
    parameter int NHI = 32,
    parameter int DW  = 32,
    parameter int AW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLO-1:0]  lo_empty,
    input  logic [NLO-1:0]  lo_nempty,
    input  logic [NLO-1:0]  lo_nfull,
    input  logic [NLO-1:0]  lo_full,
    input  logic [NHI-1:0]  hi_nempty,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_lo,
    output logic            irq_hi
);

    logic [NLO-1:0]  ev_lo, pend_lo, en_lo, clr_lo;
    logic [NHI-1:0]  ev_hi, pend_hi, en_hi, clr_hi;
    qcfg_t [NLO-1:0] cfg;

    qirq_lo_detect #(.N(NLO)) u_lo_det (
        .clk(clk), .rst_n(rst_n),
        .f_empty(lo_empty), .f_nempty(lo_nempty),
        .f_nfull(lo_nfull), .f_full(lo_full),
        .cfg(cfg), .ev(ev_lo)
    );

    qirq_hi_detect #(.N(NHI)) u_hi_det (
        .clk(clk), .rst_n(rst_n), .f_nempty(hi_nempty), .ev(ev_hi)
    );

    qirq_sticky #(.N(NLO)) u_pend_lo (
        .clk(clk), .rst_n(rst_n), .ev(ev_lo), .clr(clr_lo), .pend(pend_lo)
    );

    qirq_sticky #(.N(NHI)) u_pend_hi (
        .clk(clk), .rst_n(rst_n), .ev(ev_hi), .clr(clr_hi), .pend(pend_hi)
    );

    qirq_regfile #(.NLO(NLO), .NHI(NHI), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .pend_lo(pend_lo), .pend_hi(pend_hi),
        .en_lo(en_lo), .en_hi(en_hi), .cfg(cfg),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .rdata(reg_rdata)
    );

    // Group interrupt lines: any enabled pending bit.
    assign irq_lo = |(pend_lo & en_lo);
    assign irq_hi = |(pend_hi & en_hi);

    // R8: a raised line always has a pending source in its own group.
    a_r8_lo_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (pend_lo != '0));
    a_r8_hi_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (pend_hi != '0));
    // R1: both lines are low on the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_lo && !irq_hi));

endmodule

// File: tb/qstat_irq_gen_bench.sv
// Self-checking bench: directed corner cases first, then seeded random
// flags and register writes, checked against a cycle model.
module qstat_irq_gen_bench;

    localparam int  NLO    = 32;
    localparam int  NHI    = 32;
    localparam time CLK_PD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NLO-1:0] lo_e = '0, lo_ne = '0, lo_nf = '0, lo_f = '0;
    logic [NHI-1:0] hi_ne = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq_lo, irq_hi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Cycle model state.
    logic [NLO-1:0] m_pe, m_pne, m_pnf, m_pf, m_st_lo, m_en_lo;
    logic [NHI-1:0] m_phi, m_st_hi, m_en_hi;
    logic [2:0]     m_cfg [NLO];

    always #(CLK_PD/2) clk = ~clk;

    qstat_irq_gen u_qstat_irq_gen (
        .clk(clk), .rst_n(rst_n),
        .lo_empty(lo_e), .lo_nempty(lo_ne), .lo_nfull(lo_nf), .lo_full(lo_f),
        .hi_nempty(hi_ne),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    function automatic logic pick(input logic [1:0] s, input logic a, b, c, d);
        return (s == 2'd0) ? a : (s == 2'd1) ? b : (s == 2'd2) ? c : d;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            4'd0: r = m_st_lo;
            4'd1: r = m_st_hi;
            4'd2: r = m_en_lo;
            4'd3: r = m_en_hi;
            4'd4, 4'd5, 4'd6, 4'd7:
                for (int k = 0; k < 8; k++) r[4*k +: 3] = m_cfg[(a-4)*8 + k];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // One clock cycle: drive the write, advance the model, end at negedge.
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d);
        logic [NLO-1:0] ev_lo, clr_lo;
        logic [NHI-1:0] ev_hi, clr_hi;
        for (int q = 0; q < NLO; q++) begin
            logic cur, prv;
            cur = pick(m_cfg[q][1:0], lo_e[q], lo_ne[q], lo_nf[q], lo_f[q]);
            prv = pick(m_cfg[q][1:0], m_pe[q], m_pne[q], m_pnf[q], m_pf[q]);
            ev_lo[q] = m_cfg[q][2] ? (prv & ~cur) : (cur & ~prv);
        end
        ev_hi  = hi_ne & ~m_phi;
        clr_lo = (we && a == 4'd0) ? d : '0;
        clr_hi = (we && a == 4'd1) ? d : '0;
        reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        m_st_lo = (m_st_lo & ~clr_lo) | ev_lo;
        m_st_hi = (m_st_hi & ~clr_hi) | ev_hi;
        if (we && a == 4'd2) m_en_lo = d;
        if (we && a == 4'd3) m_en_hi = d;
        if (we && a >= 4'd4 && a <= 4'd7)
            for (int k = 0; k < 8; k++) m_cfg[(a-4)*8 + k] = d[4*k +: 3];
        m_pe = lo_e; m_pne = lo_ne; m_pnf = lo_nf; m_pf = lo_f; m_phi = hi_ne;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_st_lo = '0; m_st_hi = '0; m_en_lo = '0; m_en_hi = '0;
        for (int q = 0; q < NLO; q++) m_cfg[q] = '0;
        m_pe = lo_e; m_pne = lo_ne; m_pnf = lo_nf; m_pf = lo_f; m_phi = hi_ne;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R11: flags high across reset release, default codes watch E rising.
        lo_e = '1; hi_ne = '1;
        do_reset();
        step(1'b0, 4'd0, '0);
        step(1'b0, 4'd0, '0);
        chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
        chk("R1 irq_hi", {31'd0, irq_hi}, 32'd0);
        for (int a = 0; a < 8; a++) rd_chk("R1/R11 reset word", 4'(a), 32'd0);

        // R3/R4: falling transitions ignored under rising codes.
        lo_e = '0; hi_ne = '0;
        step(1'b0, 4'd0, '0);
        rd_chk("R3 fall ignored", 4'd0, 32'd0);
        rd_chk("R4 hi fall ignored", 4'd1, 32'd0);

        // Queue 3: watch nearly-full rising; enable it.
        step(1'b1, 4'd4, 32'h0000_2000);
        step(1'b1, 4'd2, 32'h0000_0008);
        rd_chk("R10 cfg readback", 4'd4, 32'h0000_2000);

        // R2: other flags of queue 3 do not trigger.
        lo_e[3] = 1'b1; lo_ne[3] = 1'b1; lo_f[3] = 1'b1;
        step(1'b0, 4'd0, '0);
        rd_chk("R2 unselected flags", 4'd0, 32'd0);
        chk("R8 irq_lo idle", {31'd0, irq_lo}, 32'd0);

        lo_nf[3] = 1'b1;
        step(1'b0, 4'd0, '0);
        rd_chk("R2 selected flag", 4'd0, 32'h0000_0008);
        chk("R8 irq_lo raised", {31'd0, irq_lo}, 32'd1);

        // R5: sticky after flag returns.
        lo_nf[3] = 1'b0; lo_e[3] = 1'b0; lo_ne[3] = 1'b0; lo_f[3] = 1'b0;
        step(1'b0, 4'd0, '0);
        rd_chk("R5 sticky", 4'd0, 32'h0000_0008);
        chk("R5 irq held", {31'd0, irq_lo}, 32'd1);

        // R6: zeros leave the bit, a one clears it.
        step(1'b1, 4'd0, 32'hFFFF_FFF7);
        rd_chk("R6 zero keeps", 4'd0, 32'h0000_0008);
        step(1'b1, 4'd0, 32'h0000_0008);
        rd_chk("R6 one clears", 4'd0, 32'd0);
        chk("R8 irq_lo cleared", {31'd0, irq_lo}, 32'd0);

        // R3: queue 5 watches full falling (code 111).
        step(1'b1, 4'd4, 32'h0070_2000);
        lo_f[5] = 1'b1;
        step(1'b0, 4'd0, '0);
        rd_chk("R3 rise ignored", 4'd0, 32'd0);
        lo_f[5] = 1'b0;
        step(1'b0, 4'd0, '0);
        rd_chk("R3 fall recorded", 4'd0, 32'h0000_0020);
        chk("R9 disabled no irq", {31'd0, irq_lo}, 32'd0);

        // R4/R9: upper queue 8 (global 40).
        hi_ne[8] = 1'b1;
        step(1'b0, 4'd0, '0);
        rd_chk("R4 hi rise", 4'd1, 32'h0000_0100);
        chk("R9 hi disabled", {31'd0, irq_hi}, 32'd0);
        hi_ne[8] = 1'b0;
        step(1'b0, 4'd0, '0);
        rd_chk("R4 hi fall kept", 4'd1, 32'h0000_0100);
        step(1'b1, 4'd3, 32'h0000_0100);
        chk("R9 enable raises irq_hi", {31'd0, irq_hi}, 32'd1);
        chk("R8 groups independent", {31'd0, irq_lo}, 32'd0);

        // R7: event and clear on the same edge.
        hi_ne[8] = 1'b1;
        step(1'b1, 4'd1, 32'h0000_0100);
        rd_chk("R7 set wins", 4'd1, 32'h0000_0100);
        step(1'b1, 4'd1, 32'h0000_0100);
        rd_chk("R7 later clear", 4'd1, 32'd0);
        chk("R8 irq_hi cleared", {31'd0, irq_hi}, 32'd0);

        // R10: unmapped write is ignored and reads zero.
        step(1'b1, 4'd12, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped read", 4'd12, 32'd0);
        rd_chk("R10 enable intact", 4'd2, 32'h0000_0008);
        rd_chk("R10 cfg intact", 4'd4, 32'h0070_2000);

        // Random phase against the cycle model.
        lo_e = '0; lo_ne = '0; lo_nf = '0; lo_f = '0; hi_ne = '0;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic        we;
            logic [3:0]  a;
            logic [31:0] d;
            lo_e  ^= $urandom & $urandom & $urandom;
            lo_ne ^= $urandom & $urandom & $urandom;
            lo_nf ^= $urandom & $urandom & $urandom;
            lo_f  ^= $urandom & $urandom & $urandom;
            hi_ne ^= $urandom & $urandom & $urandom;
            we = ($urandom % 4) == 0;
            a  = 4'($urandom % 13);
            d  = $urandom;
            step(we, a, d);
            chk("R8 random irq_lo", {31'd0, irq_lo}, {31'd0, |(m_st_lo & m_en_lo)});
            chk("R8 random irq_hi", {31'd0, irq_hi}, {31'd0, |(m_st_hi & m_en_hi)});
            a = 4'($urandom % 13);
            rd_chk("R10 random readback", a, model_read(a));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule